// File: doc/BRIEF.md
# Nibble-RAM Return Stack

This block keeps a stack of 12-bit return addresses in a RAM that is only four bits wide. Each stack entry occupies a slot of four consecutive nibbles. The three data nibbles sit at offsets 1, 2 and 3 from the slot base, with the most significant nibble at offset 1. Offset 0 of every slot is left alone by stack traffic. An 8-bit return pointer names the slot base of the top entry, and it moves by four on every push and every pop.

Commands arrive on a valid/ready stream. Each command carries a push/pop flag and, for a push, the 12-bit value. Popped values leave on a second valid/ready stream. The back-pressure rules are as follows:
- A command is taken only when `cmd_valid` and `cmd_ready` are both high at a clock edge.
- `cmd_ready` is low while a sequence runs, while a popped value waits to be taken, and while a pointer load is requested.
- A popped value stays on `rd_data`, with `rd_valid` high, until `rd_ready` is sampled high.

Each accepted command then runs three RAM cycles, and each of those cycles advances only when `ram_gnt` is high. Software sets the pointer through a plain load input after reset. The expected start value is FCh, so the first push lands in slot 0. A separate nibble port reads and writes offset 0 of any slot while no sequence runs.

Top module: `nibble_rstack`

## Requirements
- R1: After reset `rp` is 00h, `busy` is 0, `rd_valid` is 0 and `cmd_ready` is 1.
- R2: When `ld_en` is high and `busy` is low, `rp` becomes `ld_val` with bits 1:0 cleared at the next edge. A load requested while `busy` is high is ignored.
- R3: A push (`cmd_pop`=0) writes `cmd_data[11:8]` at rp+5, `[7:4]` at rp+6 and `[3:0]` at rp+7, all modulo 256. When the sequence ends, `rp` is the old value plus 4.
- R4: A pop (`cmd_pop`=1) reads offsets 1, 2 and 3 of the slot at `rp` as bits 11:8, 7:4 and 3:0. It presents them on `rd_data` with `rd_valid` high, and leaves `rp` at the old value minus 4. Values come back in last-in, first-out order.
- R5: `busy` rises at the edge that accepts a command. With `ram_gnt` held high it stays high for exactly three cycles. `cmd_ready` is low whenever `busy` is high.
- R6: In any cycle where `busy` is high and `ram_gnt` is low, the sequence does not advance and the RAM is not written.
- R7: Offset 0 of every slot keeps its contents across any number of pushes and pops.
- R8: While `busy` is low, `fn_en` with `fn_we`=1 writes `fn_wdata` at address {`fn_slot`, 00}. With `fn_we`=0 it returns that nibble on `fn_rdata` after the next edge. Nibble-port requests made while `busy` is high are ignored.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold steady and `cmd_ready` stays low.
- R10: Pointer arithmetic wraps modulo 256. A push from FCh leaves `rp` at 00h, and a pop from 00h leaves it at FCh.
- R11: A pointer load takes priority over a command in the same cycle, because `cmd_ready` is low while `ld_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_data | input | 12 | Value to push |
| rd_valid | output | 1 | Popped value available |
| rd_ready | input | 1 | Consumer takes popped value |
| rd_data | output | 12 | Popped value |
| ram_gnt | input | 1 | RAM cycle granted to the stack this cycle |
| ld_en | input | 1 | Load the pointer |
| ld_val | input | 8 | Pointer load value (bits 1:0 dropped) |
| rp | output | 8 | Current return pointer |
| busy | output | 1 | Push or pop sequence in progress |
| fn_en | input | 1 | Nibble-port request |
| fn_we | input | 1 | Nibble-port write (1) or read (0) |
| fn_slot | input | 6 | Slot index for the nibble port |
| fn_wdata | input | 4 | Nibble to write |
| fn_rdata | output | 4 | Nibble read back |

## Verification
The assertions assume that `ram_gnt` can take any value in any cycle, and that `cmd_valid` may be held while `cmd_ready` is low. They also assume that a consumer may hold `rd_ready` low for any length of time. They do not assume the pointer was loaded, so an unloaded pointer simply starts at 00h. The stimulus offers commands only at falling edges and drops `cmd_valid` right after each acceptance. It stalls the grant in one push and holds back `rd_ready` in one pop. It offers loads and nibble writes while a push runs, and offers a load and a command together in one cycle.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  // Width of one RAM word and the pointer; shared by all submodules.
  localparam int unsigned NRS_NIB_W = 4;
  localparam int unsigned NRS_PTR_W = 8;

  // Phase counter width for a given number of nibbles per entry.
  function automatic int unsigned phase_bits(input int unsigned nper);
    return (nper > 1) ? $clog2(nper) : 1;
  endfunction
endpackage

// File: rtl/nrs_ptr.sv
module nrs_ptr #(
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned SLOT_LG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] rp
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(1) << SLOT_LG;
  localparam logic [PTR_W-1:0] MASK = STEP - PTR_W'(1);

  logic [PTR_W-1:0] rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   rp_q <= '0;
    else if (ld)  rp_q <= ld_val & ~MASK;
    else if (inc) rp_q <= rp_q + STEP;
    else if (dec) rp_q <= rp_q - STEP;
  end

  assign rp = rp_q;

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_q & MASK) == '0); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rp_q) && !$past(ld)) |->
      (rp_q == $past(rp_q) + STEP || rp_q == $past(rp_q) - STEP)); // R10
endmodule

// File: rtl/nrs_seq.sv
module nrs_seq #(
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NPE     = 3,
  parameter int unsigned SLOT_LG = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   start_pop,
  input  logic [NIB_W*NPE-1:0]   push_data,
  input  logic [PTR_W-1:0]       rp,
  input  logic                   gnt,
  output logic                   busy,
  output logic                   is_pop,
  output logic [PTR_W-1:0]       ram_addr,
  output logic                   ram_we,
  output logic [NIB_W-1:0]       ram_wdata,
  output logic                   step,
  output logic                   last
);
  localparam int unsigned ENT_W = NIB_W * NPE;
  localparam int unsigned PH_W  = nrs_pkg::phase_bits(NPE);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(1) << SLOT_LG;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(NPE - 1);

  logic             busy_q, pop_q;
  logic [PH_W-1:0]  phase_q;
  logic [PTR_W-1:0] base_q;
  logic [ENT_W-1:0] hold_q;

  assign step = busy_q && gnt;
  assign last = step && (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pop_q   <= 1'b0;
      phase_q <= '0;
      base_q  <= '0;
      hold_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      pop_q   <= start_pop;
      phase_q <= '0;
      base_q  <= start_pop ? rp : rp + STEP;
      hold_q  <= push_data;
    end else if (step) begin
      hold_q <= hold_q << NIB_W;
      if (last) busy_q <= 1'b0;
      else      phase_q <= phase_q + PH_W'(1);
    end
  end

  assign busy      = busy_q;
  assign is_pop    = pop_q;
  assign ram_addr  = base_q + PTR_W'(phase_q) + PTR_W'(1);
  assign ram_we    = step && !pop_q;
  assign ram_wdata = hold_q[ENT_W-1 -: NIB_W];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !gnt) |=> (busy_q && $stable(phase_q) && $stable(base_q))); // R6

  AST_SLOT_BASE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[SLOT_LG-1:0] != '0)); // R7

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (phase_q <= PH_LAST)); // R5
endmodule

// File: rtl/nrs_gather.sv
module nrs_gather #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NPE   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic                 last,
  input  logic [NIB_W-1:0]     nib,
  input  logic                 rd_ready,
  output logic                 rd_valid,
  output logic [NIB_W*NPE-1:0] rd_data
);
  localparam int unsigned ENT_W = NIB_W * NPE;

  logic [ENT_W-1:0] asm_q, out_q;
  logic             vld_q;
  logic [ENT_W-1:0] asm_nx;

  assign asm_nx = {asm_q[ENT_W-NIB_W-1:0], nib};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (vld_q && rd_ready) vld_q <= 1'b0;
      if (cap) begin
        asm_q <= asm_nx;
        if (last) begin
          out_q <= asm_nx;
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rd_ready) |=> (vld_q && $stable(out_q))); // R9
endmodule

// File: rtl/nrs_ram.sv
module nrs_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/nibble_rstack.sv
module nibble_rstack #(
  parameter int unsigned PTR_W = nrs_pkg::NRS_PTR_W,
  parameter int unsigned NIB_W = nrs_pkg::NRS_NIB_W,
  parameter int unsigned NPE   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_pop,
  input  logic [NIB_W*NPE-1:0]        cmd_data,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic [NIB_W*NPE-1:0]        rd_data,
  input  logic                        ram_gnt,
  input  logic                        ld_en,
  input  logic [PTR_W-1:0]            ld_val,
  output logic [PTR_W-1:0]            rp,
  output logic                        busy,
  input  logic                        fn_en,
  input  logic                        fn_we,
  input  logic [PTR_W-$clog2(NPE+1)-1:0] fn_slot,
  input  logic [NIB_W-1:0]            fn_wdata,
  output logic [NIB_W-1:0]            fn_rdata
);
  localparam int unsigned SLOT_LG = $clog2(NPE + 1);

  logic             seq_busy, seq_pop, seq_we, seq_step, seq_last;
  logic [PTR_W-1:0] seq_addr;
  logic [NIB_W-1:0] seq_wdata;
  logic             idle, ld_fire, cmd_fire, fn_ok, fn_wr;
  logic             ram_we;
  logic [PTR_W-1:0] ram_addr;
  logic [NIB_W-1:0] ram_wdata, ram_rdata;
  logic [NIB_W-1:0] fn_rd_q;

  assign idle      = !seq_busy;
  assign ld_fire   = ld_en && idle;
  assign cmd_ready = idle && !rd_valid && !ld_en;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign fn_ok     = fn_en && idle;
  assign fn_wr     = fn_ok && fn_we;

  nrs_ptr #(.PTR_W(PTR_W), .SLOT_LG(SLOT_LG)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld(ld_fire), .ld_val(ld_val),
    .inc(seq_last && !seq_pop), .dec(seq_last && seq_pop),
    .rp(rp)
  );

  nrs_seq #(.PTR_W(PTR_W), .NIB_W(NIB_W), .NPE(NPE), .SLOT_LG(SLOT_LG)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_fire), .start_pop(cmd_pop), .push_data(cmd_data),
    .rp(rp), .gnt(ram_gnt),
    .busy(seq_busy), .is_pop(seq_pop),
    .ram_addr(seq_addr), .ram_we(seq_we), .ram_wdata(seq_wdata),
    .step(seq_step), .last(seq_last)
  );

  // Port sharing: the sequencer owns the RAM while busy, the nibble port otherwise.
  assign ram_addr  = seq_busy ? seq_addr : {fn_slot, SLOT_LG'(0)};
  assign ram_wdata = seq_busy ? seq_wdata : fn_wdata;
  assign ram_we    = seq_we || fn_wr;

  nrs_ram #(.AW(PTR_W), .DW(NIB_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  nrs_gather #(.NIB_W(NIB_W), .NPE(NPE)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .cap(seq_step && seq_pop), .last(seq_last), .nib(ram_rdata),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)               fn_rd_q <= '0;
    else if (fn_ok && !fn_we) fn_rd_q <= ram_rdata;
  end

  assign fn_rdata = fn_rd_q;
  assign busy     = seq_busy;

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !cmd_ready); // R5

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_we && fn_wr)); // R8

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> seq_busy); // R5

  AST_NO_CMD_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> !cmd_ready); // R9
endmodule

// File: tb/nibble_rstack_bench.sv
module nibble_rstack_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_pop = 1'b0;
  logic [11:0] cmd_data = '0;
  logic        rd_ready = 1'b1, ram_gnt = 1'b1;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_val = '0;
  logic        fn_en = 1'b0, fn_we = 1'b0;
  logic [5:0]  fn_slot = '0;
  logic [3:0]  fn_wdata = '0;
  logic        cmd_ready, rd_valid, busy;
  logic [11:0] rd_data;
  logic [7:0]  rp;
  logic [3:0]  fn_rdata;

  int nchk = 0, nerr = 0;
  logic [7:0] exp_rp = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_rstack u_nibble_rstack (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_pop(cmd_pop), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .ram_gnt(ram_gnt), .ld_en(ld_en), .ld_val(ld_val), .rp(rp), .busy(busy),
    .fn_en(fn_en), .fn_we(fn_we), .fn_slot(fn_slot), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_ptr(input logic [7:0] v);
    @(negedge clk); ld_en = 1'b1; ld_val = v;
    @(negedge clk); ld_en = 1'b0;
    exp_rp = {v[7:2], 2'b00};
    chk("R2 pointer load", rp, exp_rp);
  endtask

  task automatic fn_write(input logic [5:0] s, input logic [3:0] d);
    @(negedge clk); fn_en = 1'b1; fn_we = 1'b1; fn_slot = s; fn_wdata = d;
    @(negedge clk); fn_en = 1'b0; fn_we = 1'b0;
  endtask

  task automatic fn_read(input logic [5:0] s, input logic [3:0] e, input string tag);
    @(negedge clk); fn_en = 1'b1; fn_we = 1'b0; fn_slot = s;
    @(negedge clk); fn_en = 1'b0;
    chk(tag, fn_rdata, e);
  endtask

  // Push with an optional grant stall and optional disturbing requests during busy.
  task automatic do_push(input logic [11:0] d, input int stall, input bit disturb);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = 1'b0; cmd_data = d; ram_gnt = (stall == 0);
    chk("R5 ready before push", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy after accept", busy, 1);
    chk("R5 not ready while busy", cmd_ready, 0);
    if (disturb) begin
      ld_en = 1'b1; ld_val = 8'h40;
      fn_en = 1'b1; fn_we = 1'b1; fn_slot = 6'd5; fn_wdata = 4'hF;
    end
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R6 busy held under stall", busy, 1);
      chk("R6 pointer held under stall", rp, exp_rp);
    end
    ram_gnt = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      ld_en = 1'b0; fn_en = 1'b0; fn_we = 1'b0;
      chk("R5 busy mid sequence", busy, 1);
    end
    @(negedge clk);
    exp_rp = exp_rp + 8'd4;
    chk("R5 busy drops after three cycles", busy, 0);
    chk("R3 pointer after push", rp, exp_rp);
  endtask

  task automatic do_pop(input logic [11:0] e, input int hold);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = 1'b1; rd_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy during pop", busy, 1);
    repeat (2) @(negedge clk);
    @(negedge clk);
    exp_rp = exp_rp - 8'd4;
    chk("R4 pop valid", rd_valid, 1);
    chk("R4 pop data", rd_data, e);
    chk("R4 pointer after pop", rp, exp_rp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R9 valid held", rd_valid, 1);
      chk("R9 data held", rd_data, e);
      chk("R9 no command while held", cmd_ready, 0);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    chk("R9 valid cleared after take", rd_valid, 0);
    chk("R9 ready after take", cmd_ready, 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rp", rp, 8'h00);
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_load;
    load_ptr(8'h37);
    load_ptr(8'hFC);
  endtask

  task automatic t_free_port;
    fn_write(6'd0, 4'hA);
    fn_write(6'd1, 4'h5);
    fn_write(6'd2, 4'hC);
    fn_write(6'd5, 4'h3);
    fn_read(6'd0, 4'hA, "R8 read slot0");
    fn_read(6'd1, 4'h5, "R8 read slot1");
    fn_read(6'd5, 4'h3, "R8 read slot5");
  endtask

  task automatic t_push_pop;
    do_push(12'hABC, 0, 1'b0);
    chk("R10 push wraps FC to 00", rp, 8'h00);
    do_push(12'h123, 0, 1'b0);
    do_push(12'h456, 0, 1'b0);
    fn_read(6'd0, 4'hA, "R7 free nibble slot0");
    fn_read(6'd1, 4'h5, "R7 free nibble slot1");
    fn_read(6'd2, 4'hC, "R7 free nibble slot2");
    do_pop(12'h456, 0);
    do_pop(12'h123, 0);
    do_pop(12'hABC, 0);
    chk("R10 pop wraps 00 to FC", rp, 8'hFC);
    fn_read(6'd0, 4'hA, "R7 free nibble after pops");
  endtask

  task automatic t_wrap_pop;
    load_ptr(8'h00);
    do_pop(12'hABC, 0);
    chk("R10 pop from 00", rp, 8'hFC);
  endtask

  task automatic t_grant_stall;
    do_push(12'h9E1, 5, 1'b0);
    fn_read(6'd0, 4'hA, "R6 free nibble after stalled push");
    do_pop(12'h9E1, 0);
  endtask

  task automatic t_backpressure;
    do_push(12'h7F2, 0, 1'b0);
    do_pop(12'h7F2, 4);
  endtask

  task automatic t_busy_ignores;
    do_push(12'h5A5, 0, 1'b1);
    chk("R2 load during busy ignored", rp, 8'h00);
    fn_read(6'd5, 4'h3, "R8 nibble write during busy ignored");
    do_pop(12'h5A5, 0);
  endtask

  task automatic t_ld_priority;
    @(negedge clk);
    ld_en = 1'b1; ld_val = 8'h11; cmd_valid = 1'b1; cmd_pop = 1'b0; cmd_data = 12'hFFF;
    #1;
    chk("R11 cmd_ready low under load", cmd_ready, 0);
    @(negedge clk);
    ld_en = 1'b0; cmd_valid = 1'b0;
    exp_rp = 8'h10;
    chk("R11 load wins", rp, 8'h10);
    chk("R11 no sequence started", busy, 0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_free_port();
    t_push_pop();
    t_wrap_pop();
    t_grant_stall();
    t_backpressure();
    t_busy_ignores();
    t_ld_priority();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule